// File: doc/BRIEF.md
# SPI Buffer Command Decoder

This block is the serial front end of a page-organised flash model. It listens to an SPI mode 0 link (active-low select, clock idling low), oversamples the link with the system clock, and turns the incoming bytes into commands. Two on-chip byte buffers can be written and read through the link. A status byte can be polled. The link can be put into a deep sleep state in which only the wake command is decoded. Commands that would start an internal programming operation on the main array are not carried out here. Instead the block raises a one-cycle start pulse with the selected buffer and the decoded page number, for logic outside the block to act on.

Sleep entry, wake-up and the programming start take effect only when the select line is released, and only if the command was exactly complete. A command cut short is discarded. The output is enabled only while a read or a status poll is driving data. The active-low reset returns the decoder to idle at once and wakes the block.

Top module: `dfl_spi_slave`

## Requirements
- R1: Opcode 84h selects buffer 1 and opcode 87h selects buffer 2 for writing. Three address bytes follow the opcode, and only the 10 least significant address bits (the last ten received) are used. Each following complete data byte is stored in the selected buffer, and the other buffer is untouched.
- R2: The buffer depth is 528 bytes when `page_bin` is 0 and 512 bytes when it is 1. A start address at or above the depth is reduced by the depth. Sequential accesses step from the last location back to location 0.
- R3: Opcode D1h reads buffer 1 and opcode D3h reads buffer 2. Both take the same three address bytes as a write, with the same folding and wrapping. Data leaves on `so` MSB first: each bit changes after a falling SCK edge and stays stable while SCK is high, and the first bit is driven after the falling edge that follows the last address bit.
- R4: `so_oe` is 0 whenever the select line is high. It drops within a few system clocks after the select line rises.
- R5: Opcode D7h returns the status byte again and again for as long as the select line stays low. Bit 7 is 1 when `busy` is 0, bit 0 equals `page_bin`, and bits 6 to 1 are 0.
- R6: Opcode B9h, sent as exactly 8 bits before the select line rises, enters sleep. While asleep every opcode other than ABh is ignored: no buffer write, no output enable, no start pulse.
- R7: Opcode ABh, sent as exactly 8 bits before the select line rises, leaves sleep. A wake opcode with fewer bits leaves the block asleep.
- R8: Opcode 83h (buffer 1) or 86h (buffer 2), followed by exactly three address bytes, raises `op_start` for one system clock after the select line rises. `op_buf` gives the buffer, and `op_page` gives address bits 22..10 when `page_bin` is 0 or bits 21..9 when it is 1.
- R9: A command whose address is incomplete, or which has extra bits beyond its exact length, has no effect. A trailing partial data byte of a write is not stored.
- R10: A low `rst_n` abandons the command in progress, clears sleep and drops `so_oe`. Clocks that arrive before the next select-line rise are ignored.
- R11: An undefined opcode is ignored until the select line rises, and `so_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the link |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Link select, active low |
| sck | input | 1 | Link clock, idle low |
| si | input | 1 | Serial data in, sampled on rising SCK |
| page_bin | input | 1 | 1 selects the 512-byte buffer size, 0 the 528-byte size |
| busy | input | 1 | Busy indication from the array controller |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (high impedance when 0) |
| op_start | output | 1 | One-cycle request to program a page from a buffer |
| op_buf | output | 1 | Buffer of the request (0 = buffer 1, 1 = buffer 2) |
| op_page | output | 13 | Page number of the request |

## Verification
A wrong buffer pointer shows at once on the next read, as a byte that does not match the write pattern. A wrap or fold fault shows exactly at location 0 or at the depth boundary, so the sweeps cross both. Decoder state faults show on the release of the select line: a missing or spurious `op_start` within a few clocks, or a sleep flag that is wrongly kept or dropped. A sleep fault is seen on the next status poll, as an enable that is present or absent when it should not be. A shift or timing fault shows on the first bit of the first output byte.

// File: rtl/dfl_pkg.sv
`timescale 1ns/1ps
package dfl_pkg;
  localparam int NBUF = 2;

  localparam logic [7:0] OPC_WR1   = 8'h84;
  localparam logic [7:0] OPC_WR2   = 8'h87;
  localparam logic [7:0] OPC_RD1   = 8'hD1;
  localparam logic [7:0] OPC_RD2   = 8'hD3;
  localparam logic [7:0] OPC_PG1   = 8'h83;
  localparam logic [7:0] OPC_PG2   = 8'h86;
  localparam logic [7:0] OPC_STAT  = 8'hD7;
  localparam logic [7:0] OPC_SLEEP = 8'hB9;
  localparam logic [7:0] OPC_WAKE  = 8'hAB;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADR, ST_WR, ST_RD, ST_STAT, ST_DONE, ST_SKIP
  } dfl_state_e;

  typedef enum logic [2:0] {
    K_NONE, K_WR, K_RD, K_PROG, K_SLEEP, K_WAKE
  } dfl_kind_e;
endpackage

// File: rtl/dfl_spi_front.sv
`timescale 1ns/1ps
module dfl_spi_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic cs_act,
  output logic cs_rise,
  output logic cs_fall,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] cs_sr_q, cs_sr_d;
  logic [LAST:0] sck_sr_q, sck_sr_d;
  logic [LAST:0] si_sr_q, si_sr_d;
  logic          cs_prev_q, sck_prev_q;
  logic          cs_now, sck_now;

  always_comb begin
    cs_sr_d  = {cs_sr_q[LAST-1:0], cs_n};
    sck_sr_d = {sck_sr_q[LAST-1:0], sck};
    si_sr_d  = {si_sr_q[LAST-1:0], si};
  end

  // select chain resets to "active" with no edge pending, so a reset taken
  // mid-transfer never sees a false select-fall afterwards
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sr_q    <= '0;
      sck_sr_q   <= '0;
      si_sr_q    <= '0;
      cs_prev_q  <= 1'b0;
      sck_prev_q <= 1'b0;
    end else begin
      cs_sr_q    <= cs_sr_d;
      sck_sr_q   <= sck_sr_d;
      si_sr_q    <= si_sr_d;
      cs_prev_q  <= cs_now;
      sck_prev_q <= sck_now;
    end
  end

  assign cs_now   = cs_sr_q[LAST];
  assign sck_now  = sck_sr_q[LAST];
  assign si_s     = si_sr_q[LAST];
  assign cs_act   = !cs_now;
  assign cs_rise  = cs_now & !cs_prev_q;
  assign cs_fall  = !cs_now & cs_prev_q;
  assign sck_rise = cs_act & sck_now & !sck_prev_q;
  assign sck_fall = cs_act & !sck_now & sck_prev_q;
endmodule

// File: rtl/dfl_buf_ram.sv
`timescale 1ns/1ps
module dfl_buf_ram #(
  parameter int DEPTH = 528,
  parameter int AW    = 10,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/dfl_cmd_ctrl.sv
`timescale 1ns/1ps
module dfl_cmd_ctrl
  import dfl_pkg::*;
#(
  parameter int STD_DEPTH = 528,
  parameter int BIN_DEPTH = 512,
  parameter int BA_W      = 10,
  parameter int PA_W      = 13
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_act,
  input  logic                      cs_rise,
  input  logic                      cs_fall,
  input  logic                      sck_rise,
  input  logic                      sck_fall,
  input  logic                      si_s,
  input  logic                      page_bin,
  input  logic                      busy,
  input  logic [NBUF-1:0][7:0]      rd_data,
  output logic [NBUF-1:0]           we_o,
  output logic [BA_W-1:0]           ptr_o,
  output logic [BA_W-1:0]           raddr_o,
  output logic [BA_W-1:0]           depth_o,
  output logic [7:0]                wdata_o,
  output logic                      so_o,
  output logic                      so_oe_o,
  output logic                      start_o,
  output logic                      obuf_o,
  output logic [PA_W-1:0]           opage_o,
  output logic                      dpd_o
);
  localparam int ADR_W     = 24;
  localparam int PG_LO_STD = BA_W;
  localparam int PG_LO_BIN = BA_W - 1;
  localparam logic [BA_W-1:0] ONE   = BA_W'(1);
  localparam logic [BA_W-1:0] D_STD = BA_W'(STD_DEPTH);
  localparam logic [BA_W-1:0] D_BIN = BA_W'(BIN_DEPTH);

  dfl_state_e        st_q, st_d;
  dfl_kind_e         kind_q, kind_d;
  logic              bsel_q, bsel_d;
  logic [7:0]        sh_q, sh_d;
  logic [2:0]        bit_q, bit_d;
  logic [1:0]        abyte_q, abyte_d;
  logic [ADR_W-1:0]  adr_q, adr_d;
  logic [BA_W-1:0]   ptr_q, ptr_d;
  logic [7:0]        tx_q, tx_d;
  logic              so_q, so_d;
  logic              oe_q, oe_d;
  logic              start_q, start_d;
  logic              obuf_q, obuf_d;
  logic [PA_W-1:0]   opage_q, opage_d;
  logic              dpd_q, dpd_d;

  logic [7:0]        byte_in;
  logic [BA_W-1:0]   depth;
  logic [BA_W-1:0]   a_in;
  logic [7:0]        stat_byte;
  logic [7:0]        rd_sel;
  logic [PA_W-1:0]   page_sel;

  function automatic logic [BA_W-1:0] fold(input logic [BA_W-1:0] a,
                                           input logic [BA_W-1:0] d);
    return (a >= d) ? a - d : a;
  endfunction

  function automatic logic [BA_W-1:0] step(input logic [BA_W-1:0] p,
                                           input logic [BA_W-1:0] d);
    return (p >= d - ONE) ? '0 : p + ONE;
  endfunction

  assign byte_in   = {sh_q[6:0], si_s};
  assign depth     = page_bin ? D_BIN : D_STD;
  assign a_in      = fold({adr_q[BA_W-9:0], byte_in}, depth);
  assign stat_byte = {~busy, 6'd0, page_bin};
  assign raddr_o   = (st_q == ST_ADR) ? a_in : ptr_q;
  assign rd_sel    = rd_data[bsel_q];
  assign page_sel  = page_bin ? adr_q[PG_LO_BIN +: PA_W] : adr_q[PG_LO_STD +: PA_W];

  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    bsel_d  = bsel_q;
    sh_d    = sh_q;
    bit_d   = bit_q;
    abyte_d = abyte_q;
    adr_d   = adr_q;
    ptr_d   = ptr_q;
    tx_d    = tx_q;
    so_d    = so_q;
    oe_d    = oe_q;
    start_d = 1'b0;
    obuf_d  = obuf_q;
    opage_d = opage_q;
    dpd_d   = dpd_q;
    we_o    = '0;

    if (!cs_act) begin
      // commit point: only an exactly complete command acts here
      if (cs_rise && st_q == ST_DONE && bit_q == 3'd0) begin
        case (kind_q)
          K_SLEEP: dpd_d = 1'b1;
          K_WAKE:  dpd_d = 1'b0;
          K_PROG: begin
            start_d = 1'b1;
            obuf_d  = bsel_q;
            opage_d = page_sel;
          end
          default: ;
        endcase
      end
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (cs_fall) begin
      st_d    = ST_OPC;
      kind_d  = K_NONE;
      bit_d   = 3'd0;
      abyte_d = 2'd0;
      oe_d    = 1'b0;
    end else if (sck_rise && st_q != ST_IDLE) begin
      sh_d  = byte_in;
      bit_d = bit_q + 3'd1;
      if (st_q == ST_DONE) begin
        st_d = ST_SKIP;
      end else if (bit_q == 3'd7) begin
        case (st_q)
          ST_OPC: begin
            if (dpd_q && byte_in != OPC_WAKE) begin
              st_d = ST_SKIP;
            end else begin
              case (byte_in)
                OPC_WR1, OPC_WR2: begin
                  kind_d = K_WR;
                  bsel_d = (byte_in == OPC_WR2);
                  st_d   = ST_ADR;
                end
                OPC_RD1, OPC_RD2: begin
                  kind_d = K_RD;
                  bsel_d = (byte_in == OPC_RD2);
                  st_d   = ST_ADR;
                end
                OPC_PG1, OPC_PG2: begin
                  kind_d = K_PROG;
                  bsel_d = (byte_in == OPC_PG2);
                  st_d   = ST_ADR;
                end
                OPC_STAT: begin
                  st_d = ST_STAT;
                  tx_d = stat_byte;
                end
                OPC_SLEEP: begin
                  kind_d = K_SLEEP;
                  st_d   = ST_DONE;
                end
                OPC_WAKE: begin
                  kind_d = K_WAKE;
                  st_d   = ST_DONE;
                end
                default: st_d = ST_SKIP;
              endcase
            end
          end
          ST_ADR: begin
            adr_d   = {adr_q[ADR_W-9:0], byte_in};
            abyte_d = abyte_q + 2'd1;
            if (abyte_q == 2'd2) begin
              case (kind_q)
                K_WR: begin
                  st_d  = ST_WR;
                  ptr_d = a_in;
                end
                K_RD: begin
                  st_d  = ST_RD;
                  tx_d  = rd_sel;
                  ptr_d = step(a_in, depth);
                end
                default: st_d = ST_DONE;
              endcase
            end
          end
          ST_WR: begin
            we_o[bsel_q] = 1'b1;
            ptr_d        = step(ptr_q, depth);
          end
          ST_RD: begin
            tx_d  = rd_sel;
            ptr_d = step(ptr_q, depth);
          end
          ST_STAT: tx_d = stat_byte;
          default: ;
        endcase
      end
    end else if (sck_fall && (st_q == ST_RD || st_q == ST_STAT)) begin
      so_d = tx_q[3'd7 - bit_q];
      oe_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      kind_q  <= K_NONE;
      bsel_q  <= 1'b0;
      sh_q    <= '0;
      bit_q   <= '0;
      abyte_q <= '0;
      adr_q   <= '0;
      ptr_q   <= '0;
      tx_q    <= '0;
      so_q    <= 1'b0;
      oe_q    <= 1'b0;
      start_q <= 1'b0;
      obuf_q  <= 1'b0;
      opage_q <= '0;
      dpd_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      kind_q  <= kind_d;
      bsel_q  <= bsel_d;
      sh_q    <= sh_d;
      bit_q   <= bit_d;
      abyte_q <= abyte_d;
      adr_q   <= adr_d;
      ptr_q   <= ptr_d;
      tx_q    <= tx_d;
      so_q    <= so_d;
      oe_q    <= oe_d;
      start_q <= start_d;
      obuf_q  <= obuf_d;
      opage_q <= opage_d;
      dpd_q   <= dpd_d;
    end
  end

  assign ptr_o   = ptr_q;
  assign depth_o = depth;
  assign wdata_o = byte_in;
  assign so_o    = so_q;
  assign so_oe_o = oe_q;
  assign start_o = start_q;
  assign obuf_o  = obuf_q;
  assign opage_o = opage_q;
  assign dpd_o   = dpd_q;
endmodule

// File: rtl/dfl_spi_slave.sv
`timescale 1ns/1ps
module dfl_spi_slave
  import dfl_pkg::*;
#(
  parameter int STD_DEPTH   = 528,
  parameter int BIN_DEPTH   = 512,
  parameter int BA_W        = 10,
  parameter int PA_W        = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            sck,
  input  logic            si,
  input  logic            page_bin,
  input  logic            busy,
  output logic            so,
  output logic            so_oe,
  output logic            op_start,
  output logic            op_buf,
  output logic [PA_W-1:0] op_page
);
  logic                 cs_act, cs_rise, cs_fall, sck_rise, sck_fall, si_s;
  logic [NBUF-1:0]      buf_we;
  logic [BA_W-1:0]      buf_ptr, buf_raddr, buf_depth;
  logic [7:0]           buf_wdata;
  logic [NBUF-1:0][7:0] buf_rdata;
  logic                 dpd;

  dfl_spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sck      (sck),
    .si       (si),
    .cs_act   (cs_act),
    .cs_rise  (cs_rise),
    .cs_fall  (cs_fall),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .si_s     (si_s)
  );

  dfl_cmd_ctrl #(
    .STD_DEPTH (STD_DEPTH),
    .BIN_DEPTH (BIN_DEPTH),
    .BA_W      (BA_W),
    .PA_W      (PA_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .cs_rise  (cs_rise),
    .cs_fall  (cs_fall),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .si_s     (si_s),
    .page_bin (page_bin),
    .busy     (busy),
    .rd_data  (buf_rdata),
    .we_o     (buf_we),
    .ptr_o    (buf_ptr),
    .raddr_o  (buf_raddr),
    .depth_o  (buf_depth),
    .wdata_o  (buf_wdata),
    .so_o     (so),
    .so_oe_o  (so_oe),
    .start_o  (op_start),
    .obuf_o   (op_buf),
    .opage_o  (op_page),
    .dpd_o    (dpd)
  );

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    dfl_buf_ram #(.DEPTH(STD_DEPTH), .AW(BA_W), .DW(8)) u_ram (
      .clk   (clk),
      .we    (buf_we[g]),
      .waddr (buf_ptr),
      .wdata (buf_wdata),
      .raddr (buf_raddr),
      .rdata (buf_rdata[g])
    );
  end
endmodule

// File: rtl/dfl_spi_slave_chk.sv
`timescale 1ns/1ps
module dfl_spi_slave_chk #(
  parameter int BA_W = 10,
  parameter int NB   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_act,
  input logic            cs_rise,
  input logic            so_oe,
  input logic            op_start,
  input logic            dpd,
  input logic [NB-1:0]   we,
  input logic [BA_W-1:0] ptr,
  input logic [BA_W-1:0] depth
);
  p_oe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !so_oe);

  p_start_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);

  p_start_on_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(cs_rise));

  p_asleep_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dpd |-> (!so_oe && we == '0));

  p_no_start_asleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> !dpd);

  p_one_buffer_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we));

  p_ptr_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we != '0) |-> (ptr < depth));
endmodule

bind dfl_spi_slave dfl_spi_slave_chk #(.BA_W(BA_W), .NB(dfl_pkg::NBUF)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_act   (cs_act),
  .cs_rise  (cs_rise),
  .so_oe    (so_oe),
  .op_start (op_start),
  .dpd      (dpd),
  .we       (buf_we),
  .ptr      (buf_ptr),
  .depth    (buf_depth)
);

// File: tb/dfl_spi_slave_tb.sv
`timescale 1ns/1ps
module dfl_spi_slave_tb;
  localparam int H = 5;

  logic clk, rst_n, cs_n, sck, si, page_bin, busy;
  logic so, so_oe, op_start, op_buf;
  logic [12:0] op_page;

  int n_chk, n_fail, n_starts, stable_err;
  logic last_buf;
  logic [12:0] last_page;
  logic [7:0] rx_sh;
  logic oe_any, oe_all;
  logic [7:0] mdl [2][528];
  bit done;

  dfl_spi_slave u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .page_bin(page_bin), .busy(busy), .so(so), .so_oe(so_oe),
    .op_start(op_start), .op_buf(op_buf), .op_page(op_page)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (op_start) begin
      n_starts++;
      last_buf  = op_buf;
      last_page = op_page;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int dep();
    return page_bin ? 512 : 528;
  endfunction

  function automatic int fold_b(input int a);
    return (a >= dep()) ? a - dep() : a;
  endfunction

  function automatic int step_b(input int p);
    return (p >= dep() - 1) ? 0 : p + 1;
  endfunction

  task automatic xbit(input logic b);
    logic s0;
    si = b;
    tick(H);
    s0 = so;
    rx_sh = {rx_sh[6:0], so};
    oe_any |= so_oe;
    oe_all &= so_oe;
    sck = 1'b1;
    tick(H - 1);
    if (so_oe && s0 !== so) stable_err++;
    tick(1);
    sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) xbit(b[i]);
  endtask

  task automatic xbits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) xbit(v[i]);
  endtask

  task automatic cs_on();
    cs_n = 1'b0;
    oe_any = 1'b0;
    oe_all = 1'b1;
    tick(4);
  endtask

  task automatic cs_off();
    tick(4);
    cs_n = 1'b1;
    tick(10);
  endtask

  task automatic send_cmd(input logic [7:0] op, input logic [23:0] a);
    xbyte(op);
    xbyte(a[23:16]);
    xbyte(a[15:8]);
    xbyte(a[7:0]);
  endtask

  task automatic wr_buf(input int b, input logic [23:0] a, input int n, input int seed);
    int idx;
    logic [7:0] d;
    cs_on();
    send_cmd(b != 0 ? 8'h87 : 8'h84, a);
    idx = fold_b(int'(a[9:0]));
    for (int i = 0; i < n; i++) begin
      d = 8'(seed + i * 13);
      xbyte(d);
      mdl[b][idx] = d;
      idx = step_b(idx);
    end
    cs_off();
  endtask

  task automatic rd_buf(input int b, input logic [23:0] a, input int n, input string tag);
    int idx;
    cs_on();
    send_cmd(b != 0 ? 8'hD3 : 8'hD1, a);
    oe_all = 1'b1;
    idx = fold_b(int'(a[9:0]));
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00);
      chk(rx_sh == mdl[b][idx], tag, rx_sh, mdl[b][idx]);
      idx = step_b(idx);
    end
    chk(oe_all == 1'b1, {tag, " so_oe held during read"}, oe_all, 1);
    cs_off();
  endtask

  task automatic rd_stat(input int n, input logic [7:0] exp, input string tag);
    cs_on();
    xbyte(8'hD7);
    oe_all = 1'b1;
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00);
      chk(rx_sh == exp, tag, rx_sh, exp);
    end
    chk(oe_all == 1'b1, {tag, " so_oe held"}, oe_all, 1);
    tick(4);
    cs_n = 1'b1;
    tick(6);
    chk(so_oe == 1'b0, "R4 so_oe low after select release", so_oe, 0);
    tick(4);
  endtask

  task automatic stat_silent(input string tag);
    cs_on();
    xbyte(8'hD7);
    oe_any = 1'b0;
    xbyte(8'h00);
    xbyte(8'h00);
    chk(oe_any == 1'b0, tag, oe_any, 0);
    cs_off();
  endtask

  task automatic prog(input int b, input logic [23:0] a, input int extra, input int total);
    cs_on();
    xbyte(b != 0 ? 8'h86 : 8'h83);
    if (total >= 24) begin
      xbits({8'h00, a}, 24);
      if (extra > 0) xbits(32'h0, extra);
    end else begin
      xbits({8'h00, a} >> (24 - total), total);
    end
    cs_off();
  endtask

  initial begin
    int s0;
    logic [23:0] pa;
    n_chk = 0; n_fail = 0; n_starts = 0; stable_err = 0;
    done = 0;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0;
    page_bin = 1'b0; busy = 1'b0;
    rx_sh = '0; oe_any = 0; oe_all = 1;
    tick(5);
    chk(so_oe == 1'b0, "R10 so_oe low in reset", so_oe, 0);
    chk(op_start == 1'b0, "R10 op_start low in reset", op_start, 0);
    rst_n = 1'b1;
    tick(10);
    chk(so_oe == 1'b0 && n_starts == 0, "R10 idle after reset", n_starts, 0);

    // R5 status
    rd_stat(3, 8'h80, "R5 status ready std");
    busy = 1'b1;
    rd_stat(2, 8'h00, "R5 status busy");
    busy = 1'b0; page_bin = 1'b1;
    rd_stat(2, 8'h81, "R5 status bin size");
    page_bin = 1'b0;

    // R1 R2 R3 full sweep of buffer 2 past its end
    wr_buf(1, 24'h000000, 530, 5);
    rd_buf(1, 24'h000000, 528, "R3 sweep read buf2");

    // R2 fold of high address with don't-care bits set, wrap through 0
    wr_buf(0, 24'hFFFFF0, 60, 77);
    rd_buf(0, 24'h0003F0, 60, "R2 folded wrap read buf1");
    rd_buf(1, 24'h0001E0, 4, "R1 buf2 untouched by buf1 write");

    // R2 binary size
    page_bin = 1'b1;
    wr_buf(1, 24'h0001FE, 4, 200);
    rd_buf(1, 24'h0001FE, 4, "R2 wrap at 511");
    rd_buf(1, 24'h000258, 1, "R2 fold 600 in bin size");
    page_bin = 1'b0;

    // R8 program start
    s0 = n_starts;
    pa = 24'h5A5A5A;
    prog(0, pa, 0, 24);
    chk(n_starts == s0 + 1, "R8 start count std", n_starts - s0, 1);
    chk(last_buf == 1'b0, "R8 op_buf buf1", last_buf, 0);
    chk(last_page == pa[22:10], "R8 page std", last_page, pa[22:10]);
    page_bin = 1'b1;
    pa = 24'h3C3C3C;
    prog(1, pa, 0, 24);
    chk(n_starts == s0 + 2, "R8 start count bin", n_starts - s0, 2);
    chk(last_buf == 1'b1, "R8 op_buf buf2", last_buf, 1);
    chk(last_page == pa[21:9], "R8 page bin", last_page, pa[21:9]);
    page_bin = 1'b0;

    // R9 incomplete or overlong commands
    s0 = n_starts;
    prog(0, 24'h123456, 0, 20);
    chk(n_starts == s0, "R9 short program ignored", n_starts - s0, 0);
    prog(0, 24'h123456, 1, 24);
    chk(n_starts == s0, "R9 long program ignored", n_starts - s0, 0);
    cs_on();
    send_cmd(8'h87, 24'h000064);
    xbyte(8'hC3);
    mdl[1][100] = 8'hC3;
    xbits(32'h1F, 5);
    cs_off();
    rd_buf(1, 24'h000064, 2, "R9 partial byte not stored");

    // R11 undefined opcode
    cs_on();
    xbyte(8'h55);
    oe_any = 1'b0;
    xbyte(8'h00);
    xbyte(8'h00);
    chk(oe_any == 1'b0, "R11 undefined opcode silent", oe_any, 0);
    cs_off();
    rd_stat(1, 8'h80, "R11 status after undefined opcode");

    // R6 R7 sleep and wake
    s0 = n_starts;
    cs_on(); xbyte(8'hB9); cs_off();
    stat_silent("R6 status ignored asleep");
    wr_buf(1, 24'h0000C8, 0, 0);
    cs_on(); send_cmd(8'h87, 24'h0000C8); xbyte(8'hEE); cs_off();
    prog(0, 24'h0ABCDE, 0, 24);
    chk(n_starts == s0, "R6 program ignored asleep", n_starts - s0, 0);
    cs_on(); xbits(32'h55, 7); cs_off();
    stat_silent("R7 short wake leaves asleep");
    cs_on(); xbyte(8'hAB); cs_off();
    rd_stat(1, 8'h80, "R7 awake status");
    rd_buf(1, 24'h0000C8, 1, "R6 write ignored asleep");

    // R9 sleep opcode with extra bit does nothing
    cs_on(); xbyte(8'hB9); xbit(1'b0); cs_off();
    rd_stat(1, 8'h80, "R9 overlong sleep ignored");

    // R10 reset cases
    cs_on(); xbyte(8'hB9); cs_off();
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(4);
    rd_stat(1, 8'h80, "R10 reset clears sleep");
    s0 = n_starts;
    cs_on();
    xbyte(8'h83);
    xbits(32'h00ABCD, 24);
    rst_n = 1'b0; tick(3); rst_n = 1'b1;
    cs_off();
    chk(n_starts == s0, "R10 reset drops program", n_starts - s0, 0);
    cs_on();
    xbyte(8'hD7);
    xbyte(8'h00);
    rst_n = 1'b0; tick(2);
    chk(so_oe == 1'b0, "R10 reset drops so_oe", so_oe, 0);
    rst_n = 1'b1; tick(3);
    oe_any = 1'b0;
    xbyte(8'h00);
    chk(oe_any == 1'b0, "R10 clocks ignored until release", oe_any, 0);
    cs_off();
    rd_stat(1, 8'h80, "R10 status after reset");

    chk(stable_err == 0, "R3 so stable while SCK high", stable_err, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule